// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit characters over a data-out line and a data-in line. One serial clock times both lines. No start, stop, parity or address bits are added to a character. Bits are sent and received least significant bit first. The serial clock idles high. Outgoing data changes on its falling edges, and incoming data is captured on its rising edges. When a character has finished, the output line keeps the level of its last bit.

The serial clock has two possible sources. In the first, a programmable divider generates the clock, which is then driven onto the clock pin. In the second, the clock comes in on that pin from an outside master and is synchronized before its edges are detected.

Each direction has a holding register in front of its shift register, so the parallel side can work while a character is on the wire:
- A writer can queue the next byte during a transfer.
- A reader can take the previous byte during a transfer.

Characters written in time go out back to back, and the clock does not stop at its idle level between them. The parallel side uses valid/ready handshakes, with flags for transmit-empty, receive-full and overrun.

A sequencer controls the clock phases. Its states are:
- `ST_IDLE`: no transfer; the clock is high.
- `ST_LOW`: the clock-low half of a bit.
- `ST_HIGH`: the clock-high half of a bit.

Its transitions are:
- IDLE→LOW (start; load the transmit shifter).
- LOW→HIGH (rising edge; sample the input).
- HIGH→LOW (falling edge; next bit, or, after the eighth bit, chain directly into the next character).
- HIGH→IDLE (character finished and nothing more to send).

Top module: `sync_serial_xcvr`

## Requirements
- R1: Each character is exactly 8 bits with no added framing bits. Bit k of the written byte is driven on `sd_o` at the (k+1)-th falling edge of the serial clock.
- R2: In internal-clock mode, `sd_o` changes only in the cycle in which `sck_o` falls. It is held through the whole high phase.
- R3: `sd_i` is captured at each rising serial-clock edge and assembled LSB first. The byte appears on `rx_data` with `rx_valid` high in the same cycle that the eighth rising edge appears on `sck_o`.
- R4: After a character, `sd_o` keeps the level of bit 7 until a new character drives the line. A transfer with no transmit data, in receive-only mode, does not change `sd_o`.
- R5: In internal-clock mode, `sck_oe` is 1 and exactly 8 low pulses appear on `sck_o` per character. `sck_o` is high whenever no transfer runs. In external mode `sck_oe` is 0.
- R6: In internal mode, each half period of the serial clock lasts `cfg_div`+1 system clocks. A full period lasts 2*(`cfg_div`+1) system clocks.
- R7: With `cfg_ext_clk`=1, the block follows a clock on `sck_i`. That clock is synchronized through two flops and may run at most at one sixth of the system clock. A character starts on a falling edge, data is driven after each detected falling edge, and data is captured after each detected rising edge.
- R8: Transmission and reception run at the same time on the same clock edges.
- R9: A byte written while a character is shifting follows it directly. The high phase between the two characters is no longer than a normal high phase.
- R10: In internal mode, these are the only conditions under which a transfer starts:
  - `tx_en`=1 and the transmit holding register is full;
  - `tx_en`=0, `rx_en`=1, and the receive holding register is empty.
  With both enables low, nothing starts, even if a byte is waiting.
- R11: If a character completes while `rx_valid` is set, `rx_overrun` is set and the new character is discarded. A read (`rx_valid` and `rx_ready`) clears both `rx_valid` and `rx_overrun`.
- R12: `tx_ready` is high while the transmit holding register is empty. A write drops `tx_ready` in the next cycle. `tx_empty` is high only when neither the holding register nor the shifter has a character pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ext_clk | input | 1 | 1: serial clock from `sck_i`; 0: internal divider |
| cfg_div | input | 8 | Divider value N; half period is N+1 system clocks |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit holding register empty; write accepted |
| tx_empty | output | 1 | No character held or shifting |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Reader takes `rx_data` |
| rx_overrun | output | 1 | A character was lost while the holding register was full |
| sck_i | input | 1 | Serial clock input (external mode) |
| sck_o | output | 1 | Serial clock output (internal mode) |
| sck_oe | output | 1 | Output enable for the clock pin |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |

## Verification
The first falling edge of `sck_o` comes one cycle after an idle write is accepted. Each low and high phase then lasts `cfg_div`+1 cycles. `rx_data` and `rx_valid` change on the same edge as the eighth rising edge of `sck_o`, and `tx_ready` changes on the edge after a handshake. The bench plays the peer by polling `sck_o` at falling system-clock edges. It drives `sd_i` as soon as it sees a low phase, reads `sd_o` at the first high sample, and checks receive results as soon as the eighth high phase is seen. Phase lengths are counted in falling-edge samples, so a gap of one extra cycle between chained characters is detected. In external mode the bench holds each clock phase for 8 cycles, which covers the 3-cycle synchronizer latency.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ssx_state_e;

endpackage

// File: rtl/ssx_clkgen.sv
// Half-period divider for the internal clock and synchronizer/edge detector
// for the external clock and its companion data input.
module ssx_clkgen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_i,
    input  logic             sd_i,
    output logic             tick,
    output logic             ext_rise,
    output logic             ext_fall,
    output logic             sd_sync
);

    logic [DIV_W-1:0]     cnt;
    logic [SYNC_STAGES:0] sck_sh;
    logic [SYNC_STAGES-1:0] sd_sh;

    // divider: reloads while stopped, counts down N..0 while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == '0) begin
            cnt <= div;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    // clock synchronizer plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sh <= '1;
            sd_sh  <= '0;
        end else begin
            sck_sh <= {sck_sh[SYNC_STAGES-1:0], sck_i};
            sd_sh  <= {sd_sh[SYNC_STAGES-2:0], sd_i};
        end
    end

    assign ext_rise = sck_sh[SYNC_STAGES-1] & ~sck_sh[SYNC_STAGES];
    assign ext_fall = ~sck_sh[SYNC_STAGES-1] & sck_sh[SYNC_STAGES];
    assign sd_sync  = sd_sh[SYNC_STAGES-1];

endmodule

// File: rtl/ssx_tx.sv
// Transmit holding register and shifter; line holds its level when idle.
module ssx_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic              load,
    input  logic              shift,
    input  logic              done,
    output logic              hold_full,
    output logic              empty,
    output logic              sd_o
);

    logic [DATA_W-1:0] hold;
    logic [DATA_W-2:0] shreg;
    logic              busy;
    logic              take;

    assign wr_ready = !hold_full;
    assign take     = load && tx_en && hold_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (wr_valid && wr_ready) begin
            hold      <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            sd_o  <= 1'b1;
            busy  <= 1'b0;
        end else if (take) begin
            sd_o  <= hold[0];
            shreg <= hold[DATA_W-1:1];
            busy  <= 1'b1;
        end else begin
            if (shift && busy) begin
                sd_o  <= shreg[0];
                shreg <= shreg >> 1;
            end
            if (done) begin
                busy <= 1'b0;
            end
        end
    end

    assign empty = !hold_full && !busy;

endmodule

// File: rtl/ssx_rx.sv
// Receive shifter and holding register with overrun detection.
module ssx_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sample,
    input  logic              sd_bit,
    input  logic              done,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              overrun
);

    logic [DATA_W-2:0] shreg;
    logic              pop;

    assign pop = rd_valid && rd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sample) begin
            shreg <= {sd_bit, shreg[DATA_W-2:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (pop) begin
                rd_valid <= 1'b0;
                overrun  <= 1'b0;
            end
            if (done && rx_en) begin
                if (rd_valid && !pop) begin
                    overrun <= 1'b1;
                end else begin
                    rd_data  <= {sd_bit, shreg};
                    rd_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ext_clk,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_overrun,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sd_i,
    output logic              sd_o
);

    localparam int BIT_CW = $clog2(DATA_W + 1);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(DATA_W - 1);
    localparam logic [BIT_CW-1:0] ALL_BITS = BIT_CW'(DATA_W);

    ssx_state_e        state, state_d;
    logic [BIT_CW-1:0] bit_cnt;
    logic              tick, ext_rise, ext_fall, sd_sync, sd_bit;
    logic              rise_evt, fall_evt, start_ok;
    logic              go_load, go_shift, go_sample, char_done;
    logic              tx_hold_full, sck_q, busy;

    assign busy     = (state != ST_IDLE);
    assign rise_evt = cfg_ext_clk ? ext_rise : tick;
    assign fall_evt = cfg_ext_clk ? ext_fall : tick;
    assign sd_bit   = cfg_ext_clk ? sd_sync : sd_i;

    // internal master starts only with work to do; a slave follows when enabled
    assign start_ok = cfg_ext_clk ? (tx_en || rx_en)
                    : (tx_en ? tx_hold_full : (rx_en && !rx_valid));

    assign char_done = go_sample && (bit_cnt == LAST_BIT);

    ssx_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy && !cfg_ext_clk),
        .div      (cfg_div),
        .sck_i    (sck_i),
        .sd_i     (sd_i),
        .tick     (tick),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall),
        .sd_sync  (sd_sync)
    );

    ssx_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .wr_data   (tx_data),
        .wr_valid  (tx_valid),
        .wr_ready  (tx_ready),
        .load      (go_load),
        .shift     (go_shift),
        .done      (char_done),
        .hold_full (tx_hold_full),
        .empty     (tx_empty),
        .sd_o      (sd_o)
    );

    ssx_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .sample   (go_sample),
        .sd_bit   (sd_bit),
        .done     (char_done),
        .rd_ready (rx_ready),
        .rd_data  (rx_data),
        .rd_valid (rx_valid),
        .overrun  (rx_overrun)
    );

    // next-state and edge actions
    always_comb begin
        state_d   = state;
        go_load   = 1'b0;
        go_shift  = 1'b0;
        go_sample = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cfg_ext_clk ? (ext_fall && start_ok) : start_ok) begin
                    go_load = 1'b1;
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (rise_evt) begin
                    go_sample = 1'b1;
                    state_d   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (fall_evt) begin
                    if (bit_cnt != ALL_BITS) begin
                        go_shift = 1'b1;
                        state_d  = ST_LOW;
                    end else if (start_ok) begin
                        go_load = 1'b1;
                        state_d = ST_LOW;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_d;
            if (go_load) begin
                bit_cnt <= '0;
            end else if (go_sample) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // registered clock output: low exactly while in the low phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
        end else begin
            sck_q <= (state_d != ST_LOW);
        end
    end

    assign sck_o  = sck_q;
    assign sck_oe = !cfg_ext_clk;

endmodule

// File: rtl/ssx_checker.sv
module ssx_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_ext_clk,
    input logic busy,
    input logic sck_o,
    input logic sd_o,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_ready,
    input logic rx_overrun
);

    logic [2:0] fall_cnt;
    logic       sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_cnt <= '0;
            sck_prev <= 1'b1;
        end else begin
            sck_prev <= sck_o;
            if (!busy) begin
                fall_cnt <= '0;
            end else if (sck_prev && !sck_o) begin
                fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

    assert_idle_clock_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_clk && !busy) |-> sck_o);

    assert_pulses_per_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_clk && !busy && $past(busy)) |-> (fall_cnt == 3'd0));

    assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_clk && !$stable(sd_o)) |-> $fell(sck_o));

    assert_write_fills_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_overrun_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> rx_valid);

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (!rx_overrun && !rx_valid));

endmodule

bind sync_serial_xcvr ssx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ext_clk (cfg_ext_clk),
    .busy        (busy),
    .sck_o       (sck_o),
    .sd_o        (sd_o),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_overrun  (rx_overrun)
);

// File: tb/sim_sync_serial_xcvr.sv
module sim_sync_serial_xcvr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ext_clk = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic       tx_en = 1'b0, rx_en = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_valid = 1'b0;
    logic       tx_ready, tx_empty;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       rx_overrun;
    logic       sck_i = 1'b1;
    logic       sck_o, sck_oe;
    logic       sd_i = 1'b0;
    logic       sd_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sync_serial_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div),
        .tx_en(tx_en), .rx_en(rx_en), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sd_i(sd_i), .sd_o(sd_o)
    );

    // divider, transmit byte, byte the peer returns
    localparam logic [23:0] VEC [4] = '{
        24'h00A53C, 24'h010180, 24'h0480FE, 24'h026E01
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_tx(input logic [7:0] d);
        while (!tx_ready) @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic rd();
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!sck_o) lows++;
        end
    endtask

    // peer on the internal clock: drive on low phase, capture at first high
    task automatic serve(input int nb, input logic [15:0] rb, output logic [15:0] gb,
                         output int hp, output int maxhi);
        int c;
        gb = '0; hp = 0; maxhi = 0;
        for (int i = 0; i < nb; i++) begin
            c = 0;
            while (sck_o) begin @(negedge clk); c++; end
            if (i > 0 && c > maxhi) maxhi = c;
            sd_i = rb[i];
            c = 0;
            while (!sck_o) begin c++; @(negedge clk); end
            if (i == 0) hp = c;
            gb[i] = sd_o;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] gb;
        int hp, maxhi, lows;
        logic lvl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sck_o == 1'b1, "R5 reset clock high", 32'(sck_o), 1);
        chk(sck_oe == 1'b1, "R5 reset clock driven", 32'(sck_oe), 1);
        chk(tx_ready == 1'b1, "R12 reset tx_ready", 32'(tx_ready), 1);
        chk(tx_empty == 1'b1, "R12 reset tx_empty", 32'(tx_empty), 1);
        chk(rx_valid == 1'b0, "R11 reset rx_valid", 32'(rx_valid), 0);
        chk(rx_overrun == 1'b0, "R11 reset overrun", 32'(rx_overrun), 0);

        // R10: enabled but nothing to send
        tx_en = 1'b1; rx_en = 1'b1;
        count_low(40, lows);
        chk(lows == 0, "R10 no start without tx data", 32'(lows), 0);

        // R10: both disabled, byte waiting
        tx_en = 1'b0; rx_en = 1'b0; cfg_div = 8'd2;
        put_tx(8'h5A);
        chk(tx_ready == 1'b0, "R12 write fills holding", 32'(tx_ready), 0);
        chk(tx_empty == 1'b0, "R12 tx_empty low when held", 32'(tx_empty), 0);
        count_low(40, lows);
        chk(lows == 0, "R10 no start when disabled", 32'(lows), 0);
        tx_en = 1'b1; rx_en = 1'b1;
        serve(8, 16'h0011, gb, hp, maxhi);
        chk(gb[7:0] == 8'h5A, "R10 held byte sent after enable", 32'(gb[7:0]), 32'h5A);
        chk(rx_valid && rx_data == 8'h11, "R3 rx after enable", 32'(rx_data), 32'h11);
        rd();

        // table of full-duplex characters
        for (int v = 0; v < 4; v++) begin
            cfg_div = VEC[v][23:16];
            put_tx(VEC[v][15:8]);
            serve(8, {8'h00, VEC[v][7:0]}, gb, hp, maxhi);
            chk(gb[7:0] == VEC[v][15:8], "R1 tx bits LSB first", 32'(gb[7:0]), 32'(VEC[v][15:8]));
            chk(hp == int'(VEC[v][23:16]) + 1, "R6 half period", 32'(hp), 32'(VEC[v][23:16]) + 1);
            chk(rx_valid == 1'b1, "R3 rx_valid at eighth rise", 32'(rx_valid), 1);
            chk(rx_data == VEC[v][7:0], "R8 rx byte in same transfer", 32'(rx_data), 32'(VEC[v][7:0]));
            chk(rx_overrun == 1'b0, "R11 no overrun", 32'(rx_overrun), 0);
            count_low(6, lows);
            chk(lows == 0, "R5 eight pulses then idle high", 32'(lows), 0);
            chk(sd_o == VEC[v][15], "R4 line keeps MSB", 32'(sd_o), 32'(VEC[v][15]));
            chk(tx_empty == 1'b1, "R12 tx_empty after char", 32'(tx_empty), 1);
            rd();
        end

        // R9 back-to-back characters, R11 overrun without reads
        cfg_div = 8'd3;
        put_tx(8'hC9);
        put_tx(8'h35);
        serve(16, 16'h7E81, gb, hp, maxhi);
        chk(gb == 16'h35C9, "R9 two chars back to back", 32'(gb), 32'h35C9);
        chk(maxhi == 4, "R9 no idle gap between chars", 32'(maxhi), 4);
        chk(rx_valid && rx_data == 8'h81, "R11 first char kept", 32'(rx_data), 32'h81);
        chk(rx_overrun == 1'b1, "R11 overrun set", 32'(rx_overrun), 1);
        count_low(30, lows);
        chk(lows == 0, "R5 idle after chained chars", 32'(lows), 0);
        rd();
        chk(rx_valid == 1'b0 && rx_overrun == 1'b0, "R11 read clears flags",
            {30'd0, rx_valid, rx_overrun}, 0);

        // R10 receive-only: starts on room, stops when full, line untouched
        cfg_div = 8'd1;
        lvl = sd_o;
        tx_en = 1'b0;
        serve(8, 16'h00C3, gb, hp, maxhi);
        chk(rx_valid && rx_data == 8'hC3, "R10 receive-only byte", 32'(rx_data), 32'hC3);
        chk(gb[7:0] == {8{lvl}}, "R4 line unchanged in receive-only", 32'(gb[7:0]), 32'({8{lvl}}));
        count_low(30, lows);
        chk(lows == 0, "R10 stop while rx full", 32'(lows), 0);
        rx_en = 1'b0;
        rd();
        count_low(30, lows);
        chk(lows == 0, "R10 no start when both disabled", 32'(lows), 0);

        // R7 external clock
        cfg_ext_clk = 1'b1;
        @(negedge clk);
        chk(sck_oe == 1'b0, "R7 clock pin released", 32'(sck_oe), 0);
        tx_en = 1'b1; rx_en = 1'b1;
        put_tx(8'h96);
        for (int i = 0; i < 8; i++) begin
            sck_i = 1'b0;
            sd_i  = 8'h4B >> i;
            repeat (8) @(negedge clk);
            gb[i] = sd_o;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(gb[7:0] == 8'h96, "R7 tx on external clock", 32'(gb[7:0]), 32'h96);
        chk(rx_valid && rx_data == 8'h4B, "R7 rx on external clock", 32'(rx_data), 32'h4B);
        chk(sd_o == 1'b1, "R4 MSB held after external char", 32'(sd_o), 1);
        rd();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule